// File: doc/BRIEF.md
# Per-Target Priority Selector with Threshold

This block sits behind the gateways of a platform-level interrupt controller, one copy per interrupt target. Each cycle it looks at the pending bits of all sources, the enable bits belonging to this target, a small priority value per source and the target's threshold. It picks the best eligible source and presents its ID, along with an interrupt request, on registered outputs.

A source is eligible when it is both pending and enabled. The best eligible source is the one with the highest priority, and lower IDs win ties. The request is raised only when that source's priority is strictly greater than the threshold. The ID output tracks the best eligible source even when the threshold masks it, so software polling the ID can see a masked candidate. ID 0 is reserved to mean that no source is eligible. Source bit `i` of every per-source vector carries ID `i+1`.

Top module: `prio_target_sel`

## Requirements
- R1: A source takes part in the selection only when its bit in `src_pend` and its bit in `src_en` are both 1. A disabled or idle source is never named on `irq_id`, whatever its priority.
- R2: Both outputs are registered. The values present at one rising clock edge appear on `irq` and `irq_id` after that edge. Whenever `irq` is 1, `irq_id` is nonzero.
- R3: `irq` is 1 only when the winning source's priority is strictly greater than `thresh`. Priority equal to the threshold gives no request, and priority 0 never gives one.
- R4: The winner is the eligible source with the largest value in `src_prio`. The priority of source ID `k` sits in bits `[(k-1)*PRIO_W +: PRIO_W]`. `irq_id` reports that source as `k`.
- R5: When several eligible sources share the largest priority, the lowest ID wins.
- R6: When the winner's priority does not exceed `thresh`, `irq_id` still shows the winner's ID and `irq` stays 0.
- R7: When no source is eligible, `irq_id` is 0 and `irq` is 0.
- R8: While `rst_n` is 0, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pend | input | NSRC | Pending bit per source, bit i is ID i+1 |
| src_en | input | NSRC | Enable bit per source for this target |
| src_prio | input | NSRC*PRIO_W | Packed priority per source |
| thresh | input | PRIO_W | Target threshold |
| irq | output | 1 | Registered interrupt request |
| irq_id | output | $clog2(NSRC+1) | Registered winning source ID, 0 = none |

## Verification
The bench drives sources whose priority equals the threshold. A design using a non-strict compare would raise `irq` there. It also drives eligible sources at priority 0. A design that treats priority 0 as absent would leave `irq_id` at 0 instead of naming the source. Ties between several sources at the top priority expose a scan that keeps the last match, which would report a higher ID. A high-priority source that is enabled but not pending, or pending but not enabled, catches a design that gates on only one of the two bits, because that design would name the wrong source. Random patterns with varied density and threshold then check the outputs against a reference model that finds the maximum first and the lowest index second.

// File: rtl/prio_target_sel.sv
module prio_target_sel #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(NSRC + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          src_pend,
  input  logic [NSRC-1:0]          src_en,
  input  logic [NSRC*PRIO_W-1:0]   src_prio,
  input  logic [PRIO_W-1:0]        thresh,
  output logic                     irq,
  output logic [ID_W-1:0]          irq_id
);

  wire [NSRC-1:0] elig = src_pend & src_en;

  logic              found;
  logic [PRIO_W-1:0] best_prio;
  logic [ID_W-1:0]   best_id;

  always_comb begin
    found     = 1'b0;
    best_prio = '0;
    best_id   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!found || src_prio[i*PRIO_W +: PRIO_W] > best_prio)) begin
        found     = 1'b1;
        best_prio = src_prio[i*PRIO_W +: PRIO_W];
        best_id   = ID_W'(i + 1);
      end
    end
  end

  wire fire = found && (best_prio > thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      irq_id <= '0;
    end else begin
      irq    <= fire;
      irq_id <= best_id;
    end
  end

endmodule

module prio_target_sel_chk #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(NSRC + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NSRC-1:0]        src_pend,
  input logic [NSRC-1:0]        src_en,
  input logic [NSRC*PRIO_W-1:0] src_prio,
  input logic [PRIO_W-1:0]      thresh,
  input logic                   irq,
  input logic [ID_W-1:0]        irq_id
);

  logic                   valid_q;
  logic [NSRC-1:0]        elig_q;
  logic [NSRC*PRIO_W-1:0] prio_q;
  logic [PRIO_W-1:0]      thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      elig_q  <= '0;
      prio_q  <= '0;
      thr_q   <= '0;
    end else begin
      valid_q <= 1'b1;
      elig_q  <= src_pend & src_en;
      prio_q  <= src_prio;
      thr_q   <= thresh;
    end
  end

  int                win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic              beaten;

  always_comb begin
    win_idx  = (irq_id == '0 || int'(irq_id) > NSRC) ? 0 : int'(irq_id) - 1;
    win_prio = prio_q[win_idx*PRIO_W +: PRIO_W];
    beaten   = 1'b0;
    for (int j = 0; j < NSRC; j++) begin
      if (elig_q[j] && (prio_q[j*PRIO_W +: PRIO_W] > win_prio ||
          (prio_q[j*PRIO_W +: PRIO_W] == win_prio && j < win_idx)))
        beaten = 1'b1;
    end
  end

  // R1
  elig_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && irq_id != '0 |-> elig_q[win_idx]);

  // R2
  req_has_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_id != '0);

  // R3
  strict_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && irq |-> win_prio > thr_q);

  // R5
  best_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && irq_id != '0 |-> !beaten);

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && elig_q == '0 |-> irq_id == '0 && !irq);

  // R8
  always @(posedge clk)
    if (!rst_n) reset_chk: assert (!irq && irq_id == '0);

endmodule

bind prio_target_sel prio_target_sel_chk #(.NSRC(NSRC), .PRIO_W(PRIO_W)) chk_i (.*);

// File: tb/prio_target_sel_tb_top.sv
`timescale 1ns/1ps
module prio_target_sel_tb_top;
  localparam int NSRC   = 32;
  localparam int PRIO_W = 3;
  localparam int ID_W   = $clog2(NSRC + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_pend = '0, src_en = '0;
  logic [NSRC*PRIO_W-1:0] src_prio = '0;
  logic [PRIO_W-1:0] thresh = '0;
  logic irq;
  logic [ID_W-1:0] irq_id;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_target_sel #(.NSRC(NSRC), .PRIO_W(PRIO_W)) dut_i (.*);

  function automatic int pr(int i);
    return int'(src_prio[i*PRIO_W +: PRIO_W]);
  endfunction

  function automatic int exp_id();
    int mx = -1;
    for (int i = 0; i < NSRC; i++)
      if (src_pend[i] && src_en[i] && pr(i) > mx) mx = pr(i);
    if (mx < 0) return 0;
    for (int i = 0; i < NSRC; i++)
      if (src_pend[i] && src_en[i] && pr(i) == mx) return i + 1;
    return 0;
  endfunction

  function automatic bit exp_irq();
    int id = exp_id();
    return id != 0 && pr(id - 1) > int'(thresh);
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(string req);
    int ei = exp_id();
    bit eq = exp_irq();
    @(posedge clk); #1;
    check(req, int'(irq_id), ei);
    check(req, int'(irq), int'(eq));
    @(negedge clk);
  endtask

  task automatic clear();
    src_pend = '0; src_en = '0; src_prio = '0; thresh = '0;
  endtask

  task automatic setp(int id, int p);
    src_prio[(id-1)*PRIO_W +: PRIO_W] = PRIO_W'(p);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    src_pend = '1; src_en = '1; src_prio = '1;
    #20;
    check("R8", int'(irq), 0);
    check("R8", int'(irq_id), 0);
    @(negedge clk); rst_n = 1'b1;
    clear();
    step("R7");
    // R1: high priority but only pending / only enabled
    clear(); setp(5, 7); setp(9, 2); src_pend[4] = 1; src_en[8] = 1; src_pend[8] = 1; thresh = 1;
    step("R1");
    src_en[4] = 1; src_pend[4] = 0; step("R1");
    // R2/R4: single source above threshold
    clear(); setp(20, 5); src_pend[19] = 1; src_en[19] = 1; thresh = 3;
    step("R2");
    // R3: equal to threshold
    thresh = 5; step("R3");
    // R3/R6: priority 0 eligible
    clear(); src_pend[2] = 1; src_en[2] = 1; step("R3");
    // R5: ties
    clear(); setp(7, 6); setp(3, 6); setp(30, 6); setp(1, 4);
    src_pend = '1; src_en = '1; thresh = 2; step("R5");
    // R6: best below threshold
    thresh = 7; step("R6");
    // R4: max at top index
    clear(); setp(NSRC, 7); setp(2, 6); src_pend = '1; src_en = '1; step("R4");
    // random mix
    for (int k = 0; k < 400; k++) begin
      int dens = $urandom_range(0, 3);
      for (int i = 0; i < NSRC; i++) begin
        src_pend[i] = ($urandom_range(0, 3) < dens);
        src_en[i]   = ($urandom_range(0, 3) < dens + 1);
        src_prio[i*PRIO_W +: PRIO_W] = PRIO_W'($urandom);
      end
      thresh = PRIO_W'($urandom);
      step("R4");
    end
    // R8: reset mid-run
    src_pend = '1; src_en = '1; src_prio = '1; thresh = '0;
    rst_n = 1'b0; #1;
    check("R8", int'(irq), 0);
    check("R8", int'(irq_id), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); n_cmp++; n_bad++; $display("FAIL watchdog: actual timeout expected done"); end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule